// File: doc/BRIEF.md
# Paged Program Counter with Indirect Jump

This block holds the fetch address for a program store that is split into pages of 256 locations. The 12-bit address is treated as a 4-bit page number above an 8-bit offset within the page. Each cycle the counter takes one of five actions: hold, step by one, load a full address for a jump, load a full address for a call, or perform an indirect jump. An indirect jump replaces only the offset bits, using an 8-bit value supplied from a register pair.

An indirect jump does not take its page from the address it sits at. It takes the page from the incremented address. At offsets 0x00 to 0xFE this is the current page. At offset 0xFF it is the following page, so an indirect jump at 0x0FF with value 0x15 lands on 0x115. A registered flag reports every update that moves the counter to a different page. Opcode decode, the return stack and the program store are handled elsewhere. They drive the one-cycle operation strobes and the operand buses.

Top module: `paged_pc`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_out` becomes 0x000 and `page_cross` becomes 0 on that edge, whatever the operation strobes are.
- R2: With only `step_en` active, `pc_out` becomes the old value plus one as a 12-bit sum. The carry moves into the page bits [11:8], and 0xFFF wraps to 0x000.
- R3: With `jump_en` active, `pc_out` becomes `jump_addr`, which may be on any page.
- R4: With `call_en` active and `jump_en` low, `pc_out` becomes `call_addr`, which may be on any page.
- R5: With `ind_en` as the winning strobe and the current offset `pc_out[7:0]` in 0x00..0xFE, `pc_out` becomes {current page, `ind_offs`}.
- R6: With `ind_en` as the winning strobe and `pc_out[7:0]` equal to 0xFF, `pc_out` becomes {current page + 1, `ind_offs`}. For example, 0x0FF with value 0x15 gives 0x115.
- R7: An indirect jump executed at 0xFFF wraps its page to 0, giving 0x0nn where nn is `ind_offs`.
- R8: When several strobes are active together, the priority order is jump, then call, then indirect, then step.
- R9: With no strobe active, `pc_out` keeps its value.
- R10: `page_cross` is 1 in exactly those cycles where the page bits [11:8] of `pc_out` differ from their value one cycle earlier. It is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| jump_en | input | 1 | Direct jump strobe |
| jump_addr | input | 12 | Full jump target |
| call_en | input | 1 | Call target load strobe |
| call_addr | input | 12 | Full call target |
| ind_en | input | 1 | Indirect jump strobe |
| ind_offs | input | 8 | Register-pair value for the new offset |
| step_en | input | 1 | Sequential increment strobe |
| pc_out | output | 12 | Current program counter |
| page_cross | output | 1 | Last update changed the page number |

## Verification
Indirect jumps are tried at three kinds of location: a mid-page offset, offset 0xFE and offset 0xFF. Together these separate taking the page from the incremented address from taking it from the current address. Runs of steps across 0x0FF and 0xFFF show whether the carry reaches the page bits and whether the counter wraps. The same cases also show whether the page-change flag rises only on a real page move. Cycles with several strobes active at once, each carrying a different operand, show which operation wins. A long stretch of mixed random strobes is then compared cycle by cycle against a behavioural model.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_STEP = 3'd1,
      OP_IND  = 3'd2,
      OP_CALL = 3'd3,
      OP_JUMP = 3'd4
   } pc_op_e;
endpackage

// File: rtl/pc_op_select.sv
module pc_op_select
   import paged_pc_pkg::*;
(
   input  logic   jump_en,
   input  logic   call_en,
   input  logic   ind_en,
   input  logic   step_en,
   output pc_op_e op
);
   // fixed priority: jump > call > indirect > step (R8)
   always_comb begin
      if (jump_en)      op = OP_JUMP;
      else if (call_en) op = OP_CALL;
      else if (ind_en)  op = OP_IND;
      else if (step_en) op = OP_STEP;
      else              op = OP_HOLD;
   end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
   import paged_pc_pkg::*;
#(
   parameter int PAGE_W        = 4,
   parameter int OFFS_W        = 8,
   parameter bit IND_FROM_NEXT = 1'b1,
   localparam int ADDR_W       = PAGE_W + OFFS_W
) (
   input  logic [ADDR_W-1:0] cur_pc,
   input  pc_op_e            op,
   input  logic [ADDR_W-1:0] jump_addr,
   input  logic [ADDR_W-1:0] call_addr,
   input  logic [OFFS_W-1:0] ind_offs,
   output logic [ADDR_W-1:0] next_pc
);
   logic [ADDR_W-1:0] inc_pc;
   logic [PAGE_W-1:0] ind_page;

   assign inc_pc = cur_pc + ADDR_W'(1);

   generate
      if (IND_FROM_NEXT) begin : g_page_next
         // page of the following location: last-offset case moves on
         assign ind_page = inc_pc[ADDR_W-1:OFFS_W];
      end else begin : g_page_cur
         assign ind_page = cur_pc[ADDR_W-1:OFFS_W];
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_JUMP: next_pc = jump_addr;
         OP_CALL: next_pc = call_addr;
         OP_IND:  next_pc = {ind_page, ind_offs};
         OP_STEP: next_pc = inc_pc;
         default: next_pc = cur_pc;
      endcase
   end
endmodule

// File: rtl/pc_page_watch.sv
module pc_page_watch #(
   parameter int PAGE_W  = 4,
   parameter int OFFS_W  = 8,
   localparam int ADDR_W = PAGE_W + OFFS_W
) (
   input  logic [ADDR_W-1:0] old_pc,
   input  logic [ADDR_W-1:0] new_pc,
   output logic              moved
);
   assign moved = old_pc[ADDR_W-1:OFFS_W] != new_pc[ADDR_W-1:OFFS_W];
endmodule

// File: rtl/paged_pc.sv
module paged_pc
   import paged_pc_pkg::*;
#(
   parameter int PAGE_W        = 4,
   parameter int OFFS_W        = 8,
   parameter bit IND_FROM_NEXT = 1'b1,
   localparam int ADDR_W       = PAGE_W + OFFS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              jump_en,
   input  logic [ADDR_W-1:0] jump_addr,
   input  logic              call_en,
   input  logic [ADDR_W-1:0] call_addr,
   input  logic              ind_en,
   input  logic [OFFS_W-1:0] ind_offs,
   input  logic              step_en,
   output logic [ADDR_W-1:0] pc_out,
   output logic              page_cross
);
   generate
      if (PAGE_W < 1 || OFFS_W < 1) begin : g_bad_geom
         $error("paged_pc: PAGE_W and OFFS_W must both be at least 1");
      end
      if (ADDR_W > 32) begin : g_bad_width
         $error("paged_pc: address wider than 32 bits is not supported");
      end
   endgenerate

   pc_op_e            op;
   logic [ADDR_W-1:0] pc_q, pc_d;
   logic              cross_q, cross_d;

   pc_op_select u_sel (
      .jump_en (jump_en),
      .call_en (call_en),
      .ind_en  (ind_en),
      .step_en (step_en),
      .op      (op)
   );

   pc_next_calc #(
      .PAGE_W        (PAGE_W),
      .OFFS_W        (OFFS_W),
      .IND_FROM_NEXT (IND_FROM_NEXT)
   ) u_calc (
      .cur_pc    (pc_q),
      .op        (op),
      .jump_addr (jump_addr),
      .call_addr (call_addr),
      .ind_offs  (ind_offs),
      .next_pc   (pc_d)
   );

   pc_page_watch #(
      .PAGE_W (PAGE_W),
      .OFFS_W (OFFS_W)
   ) u_watch (
      .old_pc (pc_q),
      .new_pc (pc_d),
      .moved  (cross_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         cross_q <= 1'b0;
      end else begin
         pc_q    <= pc_d;
         cross_q <= cross_d;
      end
   end

   assign pc_out     = pc_q;
   assign page_cross = cross_q;

   // R1: reset clears the counter and the flag
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pc_out == '0 && !page_cross));

   // R3: jump always wins and loads the full address
   a_r3_jump_load: assert property (@(posedge clk) disable iff (rst)
      jump_en |=> pc_out == $past(jump_addr));

   // R8: call wins whenever jump is idle
   a_r8_call_over_lower: assert property (@(posedge clk) disable iff (rst)
      (!jump_en && call_en) |=> pc_out == $past(call_addr));

   // R5: indirect keeps the page when not at the last offset
   a_r5_ind_same_page: assert property (@(posedge clk) disable iff (rst)
      (!jump_en && !call_en && ind_en && pc_out[OFFS_W-1:0] != '1)
      |=> (pc_out[ADDR_W-1:OFFS_W] == $past(pc_out[ADDR_W-1:OFFS_W])
           && pc_out[OFFS_W-1:0] == $past(ind_offs)));

   // R2: a lone step adds one
   a_r2_step_inc: assert property (@(posedge clk) disable iff (rst)
      (!jump_en && !call_en && !ind_en && step_en)
      |=> pc_out == $past(pc_out) + ADDR_W'(1));

   // R9: idle cycles hold the counter
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!jump_en && !call_en && !ind_en && !step_en) |=> $stable(pc_out));

   // R10: the flag is only raised on a real page change
   a_r10_cross_real: assert property (@(posedge clk) disable iff (rst)
      page_cross |-> pc_out[ADDR_W-1:OFFS_W] != $past(pc_out[ADDR_W-1:OFFS_W]));
endmodule

// File: tb/paged_pc_tb_top.sv
`timescale 1ns/1ps
module paged_pc_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        jump_en, call_en, ind_en, step_en;
   logic [11:0] jump_addr, call_addr;
   logic [7:0]  ind_offs;
   logic [11:0] pc_out;
   logic        page_cross;

   int checks = 0;
   int errors = 0;
   int model_pc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   paged_pc dut_i (
      .clk(clk), .rst(rst),
      .jump_en(jump_en), .jump_addr(jump_addr),
      .call_en(call_en), .call_addr(call_addr),
      .ind_en(ind_en), .ind_offs(ind_offs),
      .step_en(step_en),
      .pc_out(pc_out), .page_cross(page_cross)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Behavioural next-state, written from the requirements.
   // Assumes the caller is at a negedge; returns at the next negedge.
   task automatic cyc(bit j, int ja, bit c, int ca, bit i, int io, bit s, string tag);
      int nxt;
      int old;
      jump_en = j; jump_addr = ja[11:0];
      call_en = c; call_addr = ca[11:0];
      ind_en = i;  ind_offs = io[7:0];
      step_en = s;
      old = model_pc;
      if (j)      nxt = ja & 'hFFF;
      else if (c) nxt = ca & 'hFFF;
      else if (i) nxt = ((((old + 1) >> 8) & 'hF) << 8) | (io & 'hFF);
      else if (s) nxt = (old + 1) & 'hFFF;
      else        nxt = old;
      model_pc = nxt;
      @(negedge clk);
      check(tag, int'(pc_out), nxt);
      check("R10", int'(page_cross), ((nxt >> 8) != (old >> 8)) ? 1 : 0);
   endtask

   task automatic idle();
      jump_en = 0; call_en = 0; ind_en = 0; step_en = 0;
   endtask

   initial begin
      rst = 1'b1;
      idle();
      jump_addr = '0; call_addr = '0; ind_offs = '0;
      // reset while strobes are active
      @(negedge clk);
      jump_en = 1; jump_addr = 12'h7A3; step_en = 1;
      @(negedge clk);
      check("R1", int'(pc_out), 0);
      check("R1", int'(page_cross), 0);
      rst = 1'b0;
      model_pc = 0;

      cyc(0,0,0,0,0,0,1,"R2");          // 000 -> 001
      cyc(0,0,0,0,0,0,0,"R9");          // hold
      cyc(0,0,0,0,0,0,0,"R9");
      cyc(1,'h0FE,0,0,0,0,0,"R3");
      cyc(0,0,0,0,1,'h33,0,"R5");       // 0FE -> 033 (same page)
      cyc(1,'h0FF,0,0,0,0,0,"R3");
      cyc(0,0,0,0,1,'h15,0,"R6");       // 0FF -> 115
      cyc(1,'h1FF,0,0,0,0,0,"R3");
      cyc(0,0,0,0,0,0,1,"R2");          // 1FF -> 200 crosses
      cyc(1,'hFFF,0,0,0,0,0,"R3");
      cyc(0,0,0,0,0,0,1,"R2");          // FFF -> 000 wrap
      cyc(1,'hFFF,0,0,0,0,0,"R3");
      cyc(0,0,0,0,1,'h42,0,"R7");       // FFF -> 042
      cyc(0,0,1,'hA5C,0,0,0,"R4");      // call across pages
      cyc(0,0,0,0,1,'h80,0,"R5");       // A5C -> A80
      cyc(1,'h321,1,'h654,1,'h77,1,"R8");
      cyc(0,0,1,'h654,1,'h77,1,"R8");
      cyc(0,0,0,0,1,'h99,1,"R8");       // indirect beats step
      cyc(1,'h0FF,0,0,0,0,0,"R3");
      cyc(0,0,1,'h0FF,1,'h10,1,"R8");   // call beats indirect at 0FF
      cyc(0,0,0,0,1,'h10,1,"R8");       // 0FF -> 110

      for (int k = 0; k < 600; k++) begin
         bit j, c, i, s;
         string t;
         j = ($urandom_range(0, 9) == 0);
         c = ($urandom_range(0, 9) == 0);
         i = ($urandom_range(0, 4) == 0);
         s = ($urandom_range(0, 2) != 0);
         if (k % 50 == 0) begin
            j = 1; c = 0; i = 0; s = 0;
         end
         if (j)      t = "R3";
         else if (c) t = "R4";
         else if (i) t = ((model_pc & 'hFF) == 'hFF) ? "R6" : "R5";
         else if (s) t = "R2";
         else        t = "R9";
         if (k % 50 == 0)
            cyc(1, 'h0F0 | (($urandom_range(0,15)) << 8), 0, 0, 0, 0, 0, t);
         else
            cyc(j, $urandom_range(0,'hFFF), c, $urandom_range(0,'hFFF),
                i, $urandom_range(0,'hFF), s, t);
      end

      // reset mid-run
      idle();
      rst = 1'b1;
      @(negedge clk);
      check("R1", int'(pc_out), 0);
      check("R1", int'(page_cross), 0);
      rst = 1'b0;
      model_pc = 0;
      cyc(0,0,0,0,0,0,0,"R9");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule